// File: doc/BRIEF.md
# Software write-protect command decoder

This block sits beside the page-load controller of a parallel EEPROM and watches the stream of captured write cycles. Each write arrives as one clock with `wr_valid` high together with its address and data byte. The block tracks a software write-protect flag and tells the page-load controller, in the same clock as each write, whether that byte may reach the array.

With protection off, every write is accepted. With protection on, a byte reaches the array only inside a load window. A three-write key sequence opens that window. The same sequence also switches protection on if it was off. The window closes when the page-load controller reports that the page load has finished. Protection then stays on for later writes. A six-write key sequence switches protection off. When the sequence addresses are compared, the two top address bits are ignored. Any write that does not fit the sequence in progress sends the decoder back to idle. That write is then judged as an ordinary write.

The protect flag is a register with a reset default. It stands in for a nonvolatile bit.

Top module: `swp_guard`

## Requirements
- R1: After reset `prot_en` is 0. While `prot_en` is 0, every write (`wr_valid`=1) gets `wr_allow`=1 in the same cycle, including writes that belong to a key sequence.
- R2: `wr_allow` is 0 in every cycle in which `wr_valid` is 0.
- R3: Three consecutive writes form the unlock sequence: data 0xAA at address 0x5555, then data 0x55 at 0x2AAA, then data 0xA0 at 0x5555. This sequence sets `prot_en` to 1 in the cycle after its third write, whether or not `prot_en` was already 1.
- R4: While `prot_en` is 1 and no load window is open, every write gets `wr_allow`=0. This includes the writes of a key sequence.
- R5: The load window opens after the third unlock write. Every write inside the window gets `wr_allow`=1. A `load_done` pulse closes the window at the following clock edge, and a write in the same cycle as that pulse is still allowed. `prot_en` stays 1 after the window closes.
- R6: Six consecutive writes form the disable sequence: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA, 0x20 at 0x5555. This sequence clears `prot_en` in the cycle after its sixth write.
- R7: Sequence addresses are matched on `wr_addr` bits 14:0 only. Bits 16 and 15 may take any value.
- R8: A write that does not fit the sequence in progress returns the decoder to idle. That write does not count as the first step of a new sequence, and its `wr_allow` equals the inverse of `prot_en`.
- R9: Once the 0x80 step has been taken, a mismatch on any of the three remaining steps abandons the disable sequence and leaves `prot_en` unchanged.
- R10: A `load_done` pulse outside an open window has no effect. Cycles with `wr_valid`=0 do not advance or break a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle marker of a captured write |
| wr_addr | input | ADDR_W (17) | Address of the captured write |
| wr_data | input | 8 | Data byte of the captured write |
| load_done | input | 1 | Pulse from the page-load controller when a page load has finished |
| wr_allow | output | 1 | The current write may be stored in the array (combinational) |
| prot_en | output | 1 | Software write protection is enabled |

## Verification
`wr_allow` is a combinational answer to the write presented in the same cycle. `prot_en` and the window state change one clock edge after the write or `load_done` pulse that causes them. The bench drives each cycle's inputs on the falling edge and samples both outputs 1 ns later. At that moment it compares them against a behavioural model. The model holds the state in force since the last rising edge, and the bench advances it only after the comparison. So an effect of protection, unlocking or disabling is first expected on the cycle after the write that causes it. Directed sequences cover broken steps, aborted disables, set upper address bits and `load_done` coinciding with a write. A long biased random run then mixes key bytes with arbitrary traffic.

// File: rtl/swp_pkg.sv
package swp_pkg;

    // Width of the address field that takes part in sequence matching
    localparam int unsigned SEQ_ADDR_W = 15;
    localparam int unsigned BYTE_W     = 8;

    // Key writes recognised by the matcher, one bit each in the hit vector
    localparam int unsigned KEY_N     = 5;
    localparam int unsigned K_FIRST   = 0;  // 0xAA at 0x5555
    localparam int unsigned K_SECOND  = 1;  // 0x55 at 0x2AAA
    localparam int unsigned K_UNLOCK  = 2;  // 0xA0 at 0x5555
    localparam int unsigned K_ARM     = 3;  // 0x80 at 0x5555
    localparam int unsigned K_CLEAR   = 4;  // 0x20 at 0x5555

    typedef logic [KEY_N-1:0] key_hit_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_K1     = 3'd1,
        ST_K2     = 3'd2,
        ST_OPEN   = 3'd3,
        ST_ARM    = 3'd4,
        ST_ARM_K1 = 3'd5,
        ST_ARM_K2 = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       prot;
    } guard_regs_t;

    function automatic logic [SEQ_ADDR_W-1:0] key_addr(input int unsigned idx);
        logic [SEQ_ADDR_W-1:0] a;
        case (idx)
            K_SECOND: a = 15'h2AAA;
            default:  a = 15'h5555;
        endcase
        return a;
    endfunction

    function automatic logic [BYTE_W-1:0] key_data(input int unsigned idx);
        logic [BYTE_W-1:0] d;
        case (idx)
            K_FIRST:  d = 8'hAA;
            K_SECOND: d = 8'h55;
            K_UNLOCK: d = 8'hA0;
            K_ARM:    d = 8'h80;
            default:  d = 8'h20;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
    import swp_pkg::*;
(
    input  logic [SEQ_ADDR_W-1:0] addr_lo,
    input  logic [BYTE_W-1:0]     data,
    output key_hit_t              hit
);

    for (genvar i = 0; i < KEY_N; i++) begin : g_key
        assign hit[i] = (addr_lo == key_addr(i)) && (data == key_data(i));
    end

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
    import swp_pkg::*;
#(
    parameter logic PROT_RESET = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_valid,
    input  key_hit_t hit,
    input  logic     load_done,
    output logic     allow,
    output logic     prot,
    output logic     win_open
);

    guard_regs_t r_q;
    guard_regs_t r_d;

    always_comb begin
        r_d   = r_q;
        allow = 1'b0;
        if (wr_valid) begin
            // Outside the window a write is judged by the flag before this edge
            allow = !r_q.prot;
            unique case (r_q.st)
                ST_IDLE: begin
                    if (hit[K_FIRST]) r_d.st = ST_K1;
                end
                ST_K1: begin
                    r_d.st = hit[K_SECOND] ? ST_K2 : ST_IDLE;
                end
                ST_K2: begin
                    if (hit[K_UNLOCK]) begin
                        r_d.st   = ST_OPEN;
                        r_d.prot = 1'b1;
                    end else if (hit[K_ARM]) begin
                        r_d.st = ST_ARM;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
                ST_OPEN: begin
                    allow = 1'b1;
                end
                ST_ARM: begin
                    r_d.st = hit[K_FIRST] ? ST_ARM_K1 : ST_IDLE;
                end
                ST_ARM_K1: begin
                    r_d.st = hit[K_SECOND] ? ST_ARM_K2 : ST_IDLE;
                end
                ST_ARM_K2: begin
                    r_d.st = ST_IDLE;
                    if (hit[K_CLEAR]) r_d.prot = 1'b0;
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
        // The page-load controller closes the window; protection stays set
        if ((r_q.st == ST_OPEN) && load_done) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.prot <= PROT_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign prot     = r_q.prot;
    assign win_open = (r_q.st == ST_OPEN);

endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 17,
    parameter logic        PROT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load_done,
    output logic              wr_allow,
    output logic              prot_en
);

    localparam int unsigned HI_W = ADDR_W - SEQ_ADDR_W;

    logic [SEQ_ADDR_W-1:0] addr_lo;
    logic                  unused_addr_hi;
    key_hit_t              hit;
    logic                  win_open;

    // Upper address bits never take part in sequence matching
    assign addr_lo        = wr_addr[SEQ_ADDR_W-1:0];
    assign unused_addr_hi = ^wr_addr[ADDR_W-1:ADDR_W-HI_W];

    swp_key_match u_match (
        .addr_lo (addr_lo),
        .data    (wr_data),
        .hit     (hit)
    );

    swp_seq_fsm #(
        .PROT_RESET (PROT_RESET)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .hit       (hit),
        .load_done (load_done),
        .allow     (wr_allow),
        .prot      (prot_en),
        .win_open  (win_open)
    );

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk
    import swp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_valid,
    input logic [SEQ_ADDR_W-1:0] addr_lo,
    input logic [BYTE_W-1:0]     wr_data,
    input logic                  load_done,
    input logic                  wr_allow,
    input logic                  prot_en,
    input logic                  win_open
);

    // R2
    p_idle_no_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> !wr_allow);

    // R1
    p_unprot_allows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !prot_en) |-> wr_allow);

    // R4
    p_prot_needs_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && prot_en && !win_open) |-> !wr_allow);

    // R3
    p_set_by_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> $past(wr_valid && addr_lo == 15'h5555 && wr_data == 8'hA0));

    // R6
    p_clear_by_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_en) |-> $past(wr_valid && addr_lo == 15'h5555 && wr_data == 8'h20));

    // R5
    p_window_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> prot_en);

    // R5
    p_done_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && load_done) |=> (!win_open && prot_en));

    // R10
    p_quiet_keeps_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(prot_en));

endmodule

bind swp_guard swp_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .addr_lo   (addr_lo),
    .wr_data   (wr_data),
    .load_done (load_done),
    .wr_allow  (wr_allow),
    .prot_en   (prot_en),
    .win_open  (win_open)
);

// File: tb/swp_guard_bench.sv
module swp_guard_bench;

    localparam int unsigned ADDR_W = 17;
    localparam int          WD_CYC = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              load_done = 1'b0;
    logic              wr_allow;
    logic              prot_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference: flag, window and the run of key writes so far
    bit           m_prot = 0;
    bit           m_open = 0;
    logic [22:0]  hist[$];

    always #2 clk = ~clk;

    swp_guard #(.ADDR_W(ADDR_W)) u_swp_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_done (load_done),
        .wr_allow  (wr_allow),
        .prot_en   (prot_en)
    );

    function automatic logic [22:0] seq_key(input bit dis, input int i);
        logic [22:0] k;
        int j;
        j = dis ? i : (i == 2 ? 6 : i);
        case (j)
            0, 3:    k = {15'h5555, 8'hAA};
            1, 4:    k = {15'h2AAA, 8'h55};
            2:       k = {15'h5555, 8'h80};
            5:       k = {15'h5555, 8'h20};
            default: k = {15'h5555, 8'hA0};
        endcase
        return k;
    endfunction

    function automatic bit is_prefix(input bit dis);
        int len;
        len = dis ? 6 : 3;
        if (hist.size() > len) return 0;
        for (int i = 0; i < hist.size(); i++)
            if (hist[i] != seq_key(dis, i)) return 0;
        return 1;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: %s = %0b, expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                       input bit ld, input string tag);
        bit exp_allow;
        @(negedge clk);
        wr_valid  = v;
        wr_addr   = a;
        wr_data   = d;
        load_done = ld;
        #1;
        exp_allow = v && (m_open || !m_prot);
        check(tag, "wr_allow", wr_allow, exp_allow);
        check(tag, "prot_en", prot_en, m_prot);
        // advance the model to the state after the coming rising edge
        if (m_open) begin
            if (ld) m_open = 0;
        end else if (v) begin
            hist.push_back({a[14:0], d});
            if (hist.size() == 3 && is_prefix(0)) begin
                m_prot = 1;
                m_open = 1;
                hist.delete();
            end else if (hist.size() == 6 && is_prefix(1)) begin
                m_prot = 0;
                hist.delete();
            end else if (!is_prefix(0) && !is_prefix(1)) begin
                hist.delete();
            end
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string tag);
        cyc(1, a, d, 0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, tag);
    endtask

    task automatic unlock(input logic [1:0] hi, input string tag);
        wr({hi, 15'h5555}, 8'hAA, tag);
        wr({hi, 15'h2AAA}, 8'h55, tag);
        wr({hi, 15'h5555}, 8'hA0, tag);
    endtask

    task automatic disable_seq(input logic [1:0] hi, input string tag);
        wr({hi, 15'h5555}, 8'hAA, tag);
        wr({hi, 15'h2AAA}, 8'h55, tag);
        wr({hi, 15'h5555}, 8'h80, tag);
        wr({hi, 15'h5555}, 8'hAA, tag);
        wr({hi, 15'h2AAA}, 8'h55, tag);
        wr({hi, 15'h5555}, 8'h20, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(WD_CYC * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "prot_en in reset", prot_en, 1'b0);
        check("R2", "wr_allow in reset", wr_allow, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: unprotected traffic and idle cycles
        wr(17'h00010, 8'h3C, "R1");
        wr(17'h1FFFF, 8'hFF, "R1");
        idle(2, "R2");
        // R10: stray load_done with nothing open
        cyc(0, '0, '0, 1, "R10");
        wr(17'h00123, 8'h01, "R10");

        // R3 / R7: unlock with upper bits set while unprotected
        unlock(2'b11, "R7");
        wr(17'h04000, 8'h11, "R5");
        wr(17'h04001, 8'h22, "R5");
        cyc(0, '0, '0, 1, "R5");
        wr(17'h04002, 8'h33, "R4");
        idle(1, "R5");

        // R4: protected, sequence writes refused; window with done on a write
        unlock(2'b01, "R3");
        cyc(1, 17'h08000, 8'h44, 1, "R5");
        wr(17'h08001, 8'h55, "R4");
        // R10: gaps between sequence steps do not break it
        wr(17'h05555, 8'hAA, "R10");
        idle(3, "R10");
        wr(17'h02AAA, 8'h55, "R10");
        idle(2, "R10");
        wr(17'h05555, 8'hA0, "R10");
        wr(17'h00000, 8'h99, "R5");
        cyc(0, '0, '0, 1, "R5");

        // R8: breaking writes
        wr(17'h05555, 8'hAA, "R8");
        wr(17'h05555, 8'hAA, "R8");
        wr(17'h02AAA, 8'h55, "R8");
        wr(17'h05555, 8'hA0, "R8");
        wr(17'h00001, 8'h01, "R8");
        wr(17'h05555, 8'hAA, "R8");
        wr(17'h02AAB, 8'h55, "R8");
        wr(17'h05555, 8'hA0, "R8");

        // R9: disable aborted at each of the last three steps
        wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h55, "R9"); wr(17'h05555, 8'h80, "R9");
        wr(17'h05554, 8'hAA, "R9");
        wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h55, "R9"); wr(17'h05555, 8'h80, "R9");
        wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h56, "R9");
        wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h55, "R9"); wr(17'h05555, 8'h80, "R9");
        wr(17'h05555, 8'hAA, "R9"); wr(17'h02AAA, 8'h55, "R9"); wr(17'h05555, 8'hA0, "R9");
        wr(17'h00002, 8'h02, "R9");

        // R6 / R7: full disable with upper bits set
        disable_seq(2'b10, "R6");
        wr(17'h00003, 8'h03, "R6");
        wr(17'h0AAAA, 8'h77, "R1");
        // R6: disable while already unprotected keeps it off
        disable_seq(2'b00, "R6");
        wr(17'h00004, 8'h04, "R6");

        // R8: biased random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [1:0] hi;
            sel = int'($urandom_range(0, 9));
            hi  = 2'($urandom);
            case (sel)
                0: cyc(1, {hi, 15'h5555}, 8'hAA, 0, "R8");
                1: cyc(1, {hi, 15'h2AAA}, 8'h55, 0, "R8");
                2: cyc(1, {hi, 15'h5555}, 8'hA0, 0, "R8");
                3: cyc(1, {hi, 15'h5555}, 8'h80, 0, "R8");
                4: cyc(1, {hi, 15'h5555}, 8'h20, 0, "R8");
                5: cyc(0, '0, '0, 1, "R8");
                6: cyc(1, 17'($urandom), 8'($urandom), 1'($urandom), "R8");
                7: cyc(0, '0, '0, 0, "R8");
                8: unlock(hi, "R8");
                default: disable_seq(hi, "R8");
            endcase
        end

        summary();
    end

endmodule